// File: doc/BRIEF.md
# Armed-Write Nonvolatile Byte Store Controller

This block sits on a small CPU register bus and gives software access to a byte-wide nonvolatile data store of 2^ADDR_W bytes (4096 by default). Four byte registers are exposed: the low and high halves of a byte address, a data byte, and a control byte. The store itself is modelled as an internal array that is written when a timed programming cycle completes.

Writes are guarded. Software first sets an arming bit. That bit clears itself after a short window. A write-start strobe is honoured only while the arming bit is still set, only while no write is running, and only while an external flash self-programming busy input is low. A started write holds a busy flag for a parameterised number of clocks. During that time the address register is frozen and reads are refused. A programming cycle that is already running keeps going through a register reset and still commits its byte.

Reads take one clock: the addressed byte lands in the data register on the edge of the strobe write. The block also drives a CPU stall output after each accepted read and each accepted write start. It drives a level ready interrupt while the store is idle.

Top module: `nvm_guard_ctrl`

## Requirements
- R1: Register select encoding: 0 = control, 1 = data, 2 = address low byte, 3 = address high byte. The address high byte reads back as its ADDR_W-8 implemented bits with zeros above. Control bits 7..4 always read zero. The control byte reads as {0000, irq_enable(bit3), armed(bit2), busy(bit1), read_strobe(bit0)}.
- R2: After both resets, the data register reads 0, the control byte reads 0, and the stall and interrupt outputs are 0.
- R3: Writing 1 to control bit 2 sets the armed bit. It reads 1 for exactly ARM_WINDOW (4) cycles after that write edge and then clears by itself. Writing 0 to bit 2 has no effect.
- R4: A control write with bit 1 = 1 starts a write while the armed bit is set, provided the store is idle. The busy bit then reads 1 from the next cycle.
- R5: A start strobe given without arming, or given after the arming window has run out, has no effect. Busy stays 0, no stall is raised, and the stored byte is unchanged.
- R6: Busy reads 1 for exactly WRITE_CYCLES cycles after the start edge and then clears. The data byte and address present at the start edge are then held in the store.
- R7: While busy, writes to either address register are ignored.
- R8: While busy, a read strobe is ignored. The data register keeps its value and no stall is raised.
- R9: A control write with bit 0 = 1 while idle loads the addressed byte into the data register on that edge. The read strobe bit reads 1 for one cycle only.
- R10: cpu_stall is high for RD_STALL (4) cycles after an accepted read and for WR_STALL (2) cycles after an accepted write start.
- R11: ready_irq equals irq_enable AND global_ie AND NOT busy.
- R12: No write starts while flash_busy is high.
- R13: Asserting rst_n during a programming cycle clears the software registers but does not abort the cycle. Busy stays set and the byte is committed on time. Only por_n clears the write engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears the write engine |
| rst_n | input | 1 | Register reset, active low |
| bus_wen | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| global_ie | input | 1 | CPU global interrupt enable |
| flash_busy | input | 1 | Flash self-programming in progress |
| cpu_stall | output | 1 | Halts the CPU after accesses |
| ready_irq | output | 1 | Store-ready interrupt level |

## Verification
Two situations are hard to reach from the ports. The first is a reset that arrives in the middle of a programming cycle, because the software registers must clear while the engine keeps counting. The bench starts a write, pulses only rst_n a few cycles into the busy period, and then checks three things: busy still reads set, the data register reads zero, and the byte written before the reset can be read back after the full count. The second is the edge of the arming window. The bench lets exactly four idle cycles pass between arming and the strobe, then confirms that nothing starts and that the earlier content survives.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL    = 2'd0,
      SEL_DATA    = 2'd1,
      SEL_ADDR_LO = 2'd2,
      SEL_ADDR_HI = 2'd3
   } nvm_sel_e;

   localparam int CB_RD  = 0;
   localparam int CB_GO  = 1;
   localparam int CB_ARM = 2;
   localparam int CB_IE  = 3;
endpackage

// File: rtl/nvm_arm_window.sv
module nvm_arm_window #(
   parameter int WINDOW = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_req,
   output logic armed
);
   localparam int CW = $clog2(WINDOW + 1);

   logic [CW-1:0] cnt_q;
   logic          armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (arm_req) begin
         armed_q <= 1'b1;
         cnt_q   <= CW'(WINDOW);
      end else if (armed_q) begin
         if (cnt_q == CW'(1)) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q - CW'(1);
         end
      end
   end

   assign armed = armed_q;

   // R3: while armed, the remaining window stays within 1..WINDOW
   p_arm_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (cnt_q >= CW'(1) && cnt_q <= CW'(WINDOW)));
endmodule

// File: rtl/nvm_write_engine.sv
module nvm_write_engine #(
   parameter int ADDR_W       = 12,
   parameter int DATA_W       = 8,
   parameter int WRITE_CYCLES = 8300
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              busy,
   output logic              commit,
   output logic [ADDR_W-1:0] commit_addr,
   output logic [DATA_W-1:0] commit_data
);
   localparam int CW = $clog2(WRITE_CYCLES + 1);

   logic              busy_q;
   logic [CW-1:0]     cnt_q;
   logic [ADDR_W-1:0] lat_addr_q;
   logic [DATA_W-1:0] lat_data_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= CW'(WRITE_CYCLES);
      end else if (busy_q) begin
         if (cnt_q == CW'(1)) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q - CW'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (start && !busy_q) begin
         lat_addr_q <= addr_in;
         lat_data_q <= data_in;
      end
   end

   assign busy        = busy_q;
   assign commit      = busy_q && (cnt_q == CW'(1));
   assign commit_addr = lat_addr_q;
   assign commit_data = lat_data_q;

   // R6: the committing cycle is followed by an idle engine
   p_commit_ends_r6: assert property (@(posedge clk) disable iff (!por_n)
      commit |=> !busy_q);
   // R6: a busy engine never holds a spent counter
   p_busy_count_r6: assert property (@(posedge clk) disable iff (!por_n)
      busy_q |-> cnt_q != '0);
endmodule

// File: rtl/nvm_store.sv
module nvm_store #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/nvm_stall_timer.sv
module nvm_stall_timer #(
   parameter int RD_STALL = 4,
   parameter int WR_STALL = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_evt,
   input  logic wr_evt,
   output logic stall
);
   localparam int MAXS = (RD_STALL > WR_STALL) ? RD_STALL : WR_STALL;
   localparam int CW   = $clog2(MAXS + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (rd_evt)        cnt_q <= CW'(RD_STALL);
      else if (wr_evt)        cnt_q <= CW'(WR_STALL);
      else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
   end

   assign stall = (cnt_q != '0);

   // R10: an accepted read always stalls the next cycle
   p_read_stalls_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_evt |=> stall);
   // R10: the stall count never exceeds the longest configured stall
   p_stall_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(MAXS));
endmodule

// File: rtl/nvm_guard_ctrl.sv
module nvm_guard_ctrl
   import nvm_pkg::*;
#(
   parameter int ADDR_W       = 12,
   parameter int WRITE_CYCLES = 8300,
   parameter int ARM_WINDOW   = 4,
   parameter int RD_STALL     = 4,
   parameter int WR_STALL     = 2
) (
   input  logic       clk,
   input  logic       por_n,
   input  logic       rst_n,
   input  logic       bus_wen,
   input  logic [1:0] bus_sel,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       global_ie,
   input  logic       flash_busy,
   output logic       cpu_stall,
   output logic       ready_irq
);
   localparam int DATA_W = 8;
   localparam int HI_W   = ADDR_W - 8;

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr_w
         $error("nvm_guard_ctrl: ADDR_W must lie in 9..16");
      end
      if (WRITE_CYCLES < 2) begin : g_bad_wr_cycles
         $error("nvm_guard_ctrl: WRITE_CYCLES must be at least 2");
      end
      if (ARM_WINDOW < 1) begin : g_bad_window
         $error("nvm_guard_ctrl: ARM_WINDOW must be at least 1");
      end
      if (RD_STALL < 1 || WR_STALL < 1) begin : g_bad_stall
         $error("nvm_guard_ctrl: stall lengths must be at least 1");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              ie_q;
   logic              rd_q;
   logic              armed;
   logic              busy;
   logic              commit;
   logic [ADDR_W-1:0] commit_addr;
   logic [DATA_W-1:0] commit_data;
   logic [DATA_W-1:0] store_rdata;

   nvm_sel_e sel;
   assign sel = nvm_sel_e'(bus_sel);

   logic wr_ctrl, arm_req, go_req, start, rd_req;
   assign wr_ctrl = bus_wen && (sel == SEL_CTRL);
   assign arm_req = wr_ctrl && bus_wdata[CB_ARM];
   assign go_req  = wr_ctrl && bus_wdata[CB_GO];
   assign start   = go_req && armed && !busy && !flash_busy;
   assign rd_req  = wr_ctrl && bus_wdata[CB_RD] && !busy;

   nvm_arm_window #(.WINDOW(ARM_WINDOW)) u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .arm_req (arm_req),
      .armed   (armed)
   );

   nvm_write_engine #(
      .ADDR_W       (ADDR_W),
      .DATA_W       (DATA_W),
      .WRITE_CYCLES (WRITE_CYCLES)
   ) u_eng (
      .clk         (clk),
      .por_n       (por_n),
      .start       (start),
      .addr_in     (addr_q),
      .data_in     (data_q),
      .busy        (busy),
      .commit      (commit),
      .commit_addr (commit_addr),
      .commit_data (commit_data)
   );

   nvm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .we    (commit),
      .waddr (commit_addr),
      .wdata (commit_data),
      .raddr (addr_q),
      .rdata (store_rdata)
   );

   nvm_stall_timer #(.RD_STALL(RD_STALL), .WR_STALL(WR_STALL)) u_stall (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_evt (rd_req),
      .wr_evt (start),
      .stall  (cpu_stall)
   );

   // address register: no reset value, frozen while a write runs
   always_ff @(posedge clk) begin
      if (bus_wen && !busy) begin
         if (sel == SEL_ADDR_LO) addr_q[7:0]        <= bus_wdata;
         if (sel == SEL_ADDR_HI) addr_q[ADDR_W-1:8] <= bus_wdata[HI_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         ie_q   <= 1'b0;
         rd_q   <= 1'b0;
      end else begin
         rd_q <= rd_req;
         if (rd_req)                             data_q <= store_rdata;
         else if (bus_wen && sel == SEL_DATA)    data_q <= bus_wdata;
         if (wr_ctrl)                            ie_q   <= bus_wdata[CB_IE];
      end
   end

   logic [15:0] addr_ext;
   assign addr_ext = 16'(addr_q);

   always_comb begin
      unique case (sel)
         SEL_CTRL:    bus_rdata = {4'b0000, ie_q, armed, busy, rd_q};
         SEL_DATA:    bus_rdata = data_q;
         SEL_ADDR_LO: bus_rdata = addr_ext[7:0];
         SEL_ADDR_HI: bus_rdata = addr_ext[15:8];
         default:     bus_rdata = '0;
      endcase
   end

   assign ready_irq = ie_q && global_ie && !busy;

   // R4: a write only begins when the arming bit was set
   p_go_needs_arm_r4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      $rose(busy) |-> $past(armed));
   // R12: a write never begins while flash programming is busy
   p_flash_block_r12: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      $rose(busy) |-> !$past(flash_busy));
   // R7: address stays frozen across a busy cycle
   p_addr_lock_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      ($past(busy) && busy) |-> $stable(addr_q));
   // R11: interrupt is never raised while busy
   p_irq_idle_r11: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      ready_irq |-> !busy);
   // R8: a strobe while busy leaves the data register alone
   p_read_block_r8: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
      (busy && wr_ctrl && bus_wdata[CB_RD]) |=> (data_q == $past(data_q)));
endmodule

// File: tb/sim_nvm_guard_ctrl.sv
`timescale 1ns/1ps
module sim_nvm_guard_ctrl;
   localparam int W  = 40;
   localparam logic [1:0] S_CTRL = 2'd0, S_DATA = 2'd1, S_LO = 2'd2, S_HI = 2'd3;

   logic clk = 1'b0;
   logic por_n, rst_n, bus_wen, global_ie, flash_busy;
   logic [1:0] bus_sel;
   logic [7:0] bus_wdata, bus_rdata;
   logic cpu_stall, ready_irq;

   always #4 clk = ~clk;

   nvm_guard_ctrl #(.ADDR_W(12), .WRITE_CYCLES(W), .ARM_WINDOW(4),
                    .RD_STALL(4), .WR_STALL(2)) u0 (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_wen(bus_wen),
      .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .global_ie(global_ie), .flash_busy(flash_busy),
      .cpu_stall(cpu_stall), .ready_irq(ready_irq));

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [7:0] v;
   logic [7:0] ie_bits = 8'h00;

   // table of {address, data} written then read back
   localparam logic [19:0] VEC [4] = '{
      {12'h000, 8'hA5}, {12'hFFF, 8'h3C}, {12'h123, 8'h00}, {12'h800, 8'hFF}};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      bus_sel = s; bus_wdata = d; bus_wen = 1'b1;
      @(negedge clk);
      bus_wen = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s);
      bus_sel = s;
      #1;
      v = bus_rdata;
   endtask

   task automatic set_addr(input logic [11:0] a);
      wr(S_LO, a[7:0]);
      wr(S_HI, {4'h0, a[11:8]});
   endtask

   task automatic start_write(input logic [11:0] a, input logic [7:0] d);
      set_addr(a);
      wr(S_DATA, d);
      wr(S_CTRL, 8'h04 | ie_bits);
      wr(S_CTRL, 8'h02 | ie_bits);
   endtask

   task automatic read_at(input logic [11:0] a);
      set_addr(a);
      wr(S_CTRL, 8'h01 | ie_bits);
      rd(S_DATA);
   endtask

   initial begin
      por_n = 0; rst_n = 0; bus_wen = 0; bus_sel = 0; bus_wdata = 0;
      global_ie = 0; flash_busy = 0;
      repeat (3) @(negedge clk);
      por_n = 1; rst_n = 1;
      @(negedge clk);

      // R2 reset state
      rd(S_CTRL); chk("R2 ctrl", v, 8'h00);
      rd(S_DATA); chk("R2 data", v, 8'h00);
      chk("R2 stall", cpu_stall, 0);
      chk("R2 irq", ready_irq, 0);

      // R6 table walk: write, wait, read back
      for (int i = 0; i < 4; i++) begin
         start_write(VEC[i][19:8], VEC[i][7:0]);
         repeat (W) @(negedge clk);
         read_at(VEC[i][19:8]);
         chk("R6 table readback", v, VEC[i][7:0]);
      end

      // R1 register map and reserved bits
      wr(S_HI, 8'hFF); rd(S_HI); chk("R1 addr hi reserved", v, 8'h0F);
      wr(S_LO, 8'h5A); rd(S_LO); chk("R1 addr lo", v, 8'h5A);
      wr(S_CTRL, 8'hF0); rd(S_CTRL); chk("R1 ctrl upper zero", v, 8'h00);

      // R3 arming window
      wr(S_CTRL, 8'h04); rd(S_CTRL); chk("R3 armed set", v[2], 1);
      repeat (3) @(negedge clk); rd(S_CTRL); chk("R3 armed at 4th cycle", v[2], 1);
      @(negedge clk); rd(S_CTRL); chk("R3 armed cleared", v[2], 0);
      wr(S_CTRL, 8'h04); wr(S_CTRL, 8'h00); rd(S_CTRL);
      chk("R3 zero write keeps armed", v[2], 1);
      repeat (4) @(negedge clk);

      // R4, R10, R6 good write with exact timing
      start_write(12'h010, 8'h77);
      rd(S_CTRL); chk("R4 busy set", v[1], 1);
      chk("R10 write stall c1", cpu_stall, 1);
      @(negedge clk); chk("R10 write stall c2", cpu_stall, 1);
      @(negedge clk); chk("R10 write stall end", cpu_stall, 0);
      repeat (W - 3) @(negedge clk); rd(S_CTRL); chk("R6 busy last cycle", v[1], 1);
      @(negedge clk); rd(S_CTRL); chk("R6 busy cleared", v[1], 0);

      // R9, R10 read
      set_addr(12'h010);
      wr(S_CTRL, 8'h01);
      rd(S_DATA); chk("R9 read data", v, 8'h77);
      rd(S_CTRL); chk("R9 strobe bit", v[0], 1);
      chk("R10 read stall c1", cpu_stall, 1);
      @(negedge clk); rd(S_CTRL); chk("R9 strobe clears", v[0], 0);
      repeat (2) @(negedge clk); chk("R10 read stall c4", cpu_stall, 1);
      @(negedge clk); chk("R10 read stall end", cpu_stall, 0);

      // R5 expired window and unarmed strobe
      wr(S_DATA, 8'h99);
      wr(S_CTRL, 8'h04);
      repeat (4) @(negedge clk);
      wr(S_CTRL, 8'h02);
      rd(S_CTRL); chk("R5 expired no busy", v[1], 0);
      chk("R5 expired no stall", cpu_stall, 0);
      wr(S_CTRL, 8'h02);
      rd(S_CTRL); chk("R5 unarmed no busy", v[1], 0);
      repeat (W) @(negedge clk);
      read_at(12'h010); chk("R5 content kept", v, 8'h77);
      repeat (4) @(negedge clk);

      // R7, R8 lockout during a write
      start_write(12'h020, 8'h11);
      wr(S_LO, 8'h30); rd(S_LO); chk("R7 addr locked", v, 8'h20);
      wr(S_DATA, 8'h55);
      repeat (2) @(negedge clk);
      wr(S_CTRL, 8'h01);
      rd(S_DATA); chk("R8 read ignored", v, 8'h55);
      chk("R8 no stall", cpu_stall, 0);
      repeat (W) @(negedge clk);
      read_at(12'h020); chk("R7 write went to locked addr", v, 8'h11);
      repeat (4) @(negedge clk);

      // R11 interrupt
      ie_bits = 8'h08;
      wr(S_CTRL, 8'h08);
      global_ie = 1; #1; chk("R11 irq idle", ready_irq, 1);
      global_ie = 0; #1; chk("R11 irq gated", ready_irq, 0);
      global_ie = 1;
      start_write(12'h030, 8'h22);
      chk("R11 irq low while busy", ready_irq, 0);
      repeat (W) @(negedge clk);
      chk("R11 irq back", ready_irq, 1);
      ie_bits = 8'h00;
      wr(S_CTRL, 8'h00); global_ie = 0;

      // R12 flash busy blocks start
      flash_busy = 1;
      wr(S_CTRL, 8'h04); wr(S_CTRL, 8'h02);
      rd(S_CTRL); chk("R12 blocked", v[1], 0);
      flash_busy = 0;
      repeat (4) @(negedge clk);

      // R13 register reset during a write
      start_write(12'h040, 8'hC3);
      repeat (5) @(negedge clk);
      rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
      rd(S_CTRL); chk("R13 busy survives reset", v[1], 1);
      rd(S_DATA); chk("R13 data reg reset", v, 8'h00);
      repeat (W) @(negedge clk);
      rd(S_CTRL); chk("R13 busy done", v[1], 0);
      read_at(12'h040); chk("R13 byte committed", v, 8'hC3);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule